// File: doc/BRIEF.md
# Cell-Level ATM Slave Egress Port

This block is the slave end of a 16-bit cell-level ATM PHY bus in the direction where the bus master pulls cells out of the slave. Words enter from the local side through a simple write port into an internal word buffer. The block counts whole cells as they complete, and it raises a cell-available flag when at least one complete cell is waiting that has not yet been started.

The master reads with an active-low read enable. Each enable level is captured on a rising edge, and the selected word appears on the bus right after that edge. Start-of-cell is driven with the first word of each cell. Parity is optional, and its sense is selectable.

A high enable pauses the transfer in the middle of a cell. When the enable is held low across a cell boundary and another whole cell is waiting, that cell follows with no gap. A valid strobe marks the cycles on which the bus carries a real word. On all other cycles the bus holds its last values.

Top module: `atm_cell_egress`

## Requirements
- R1: During and directly after reset, rx_clav, rx_valid, rx_soc, rx_prty and wr_full are 0 and rx_data is 0.
- R2: A word appears (rx_valid = 1) only after a rising edge on which rx_enb_n was sampled low, and at most one word is delivered per such edge.
- R3: rx_clav is 1 exactly when the number of completely written cells exceeds the number of cells whose first word has already been delivered.
- R4: A new cell starts only on an edge that samples rx_enb_n low while rx_clav is 1. Its first word carries rx_soc = 1, and every other word carries rx_soc = 0.
- R5: An edge that samples rx_enb_n high delivers no word. The next edge that samples it low resumes with the next word of the same cell.
- R6: When rx_enb_n stays low across the last word of a cell and rx_clav is 1, the first word of the next cell, with rx_soc = 1, is delivered on the very next cycle.
- R7: When no cell is in progress and rx_clav is 0, a low rx_enb_n delivers nothing and rx_valid stays 0.
- R8: Words per cell equal cfg_cell_bytes[7:1], so bit 0 of the byte count is ignored. The valid range is 16 to 128 bytes (8 to 64 words).
- R9: When cfg_par_en is 1, rx_prty makes the count of ones in {rx_data, rx_prty} odd if cfg_par_odd is 1, and even if cfg_par_odd is 0. When cfg_par_en is 0, rx_prty is 0.
- R10: On every cycle with rx_valid = 0, rx_data, rx_soc and rx_prty keep their previous values.
- R11: Words leave in write order, each exactly once. wr_full is 1 when DEPTH words are stored, and a write while wr_full is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cell_bytes | input | 8 | Static cell size in bytes (16..128) |
| cfg_par_en | input | 1 | Static parity generation enable |
| cfg_par_odd | input | 1 | Static parity sense: 1 odd, 0 even |
| wr_en | input | 1 | Local-side word write strobe |
| wr_word | input | 16 | Local-side word |
| wr_full | output | 1 | Word buffer holds DEPTH words |
| rx_enb_n | input | 1 | Master read enable, active low |
| rx_clav | output | 1 | A whole unstarted cell is waiting |
| rx_data | output | 16 | Bus data word |
| rx_soc | output | 1 | First word of a cell |
| rx_prty | output | 1 | Parity of rx_data |
| rx_valid | output | 1 | Bus carries a real word this cycle |

## Verification
The bench builds the port with DEPTH = 128 words. A 16-byte cell size therefore fills the buffer with exactly sixteen cells, and a 128-byte size leaves room for two cells, so buffer-full drops and back-to-back delivery are both reachable. It sweeps cell sizes 16, 19 (odd byte count), 24, 32 and 128 across every parity setting. The read enable is driven in four ways: held low, pseudo-random, long hold-off then low, and periodic pauses. Writes come either every cycle or every third cycle. The trickle write pattern starves the reader at cell boundaries.

// File: rtl/atm_egress_pkg.sv
package atm_egress_pkg;

    localparam int WORD_W = 16;
    localparam int WPC_W  = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WPC_W-1:0]  wpc_t;

    typedef struct packed {
        word_t data;
        logic  soc;
        logic  valid;
    } beat_t;

    function automatic wpc_t cell_words(input logic [7:0] bytes);
        return {1'b0, bytes[7:1]};
    endfunction

    function automatic logic word_parity(input word_t d, input logic en, input logic odd);
        return en ? ((^d) ^ odd) : 1'b0;
    endfunction

endpackage

// File: rtl/atm_egress_buffer.sv
module atm_egress_buffer
    import atm_egress_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  wpc_t          wpc,
    input  logic          wr_en,
    input  word_t         wr_word,
    output logic          full,
    input  logic          pop,
    input  logic          cell_start,
    output word_t         head_word,
    output logic [CW-1:0] cells_ready
);

    word_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  occ;
    wpc_t           wr_idx;
    logic           wr_acc, cell_done;

    assign full      = (occ == CW'(DEPTH));
    assign wr_acc    = wr_en && !full;
    assign cell_done = wr_acc && (wr_idx == wpc - 7'd1);
    assign head_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr      <= '0;
            rd_ptr      <= '0;
            occ         <= '0;
            wr_idx      <= '0;
            cells_ready <= '0;
        end else begin
            if (wr_acc) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                wr_idx <= cell_done ? '0 : wr_idx + 7'd1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            occ         <= occ + CW'(wr_acc) - CW'(pop);
            cells_ready <= cells_ready + CW'(cell_done) - CW'(cell_start);
        end
    end

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !pop) |=> (occ == $past(occ)));      // R11
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> (occ != '0));                                   // R11
    AST_START_HAS_CELL: assert property (@(posedge clk) disable iff (rst)
        cell_start |-> (cells_ready != '0));                    // R4

endmodule

// File: rtl/atm_egress_ctrl.sv
module atm_egress_ctrl
    import atm_egress_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  wpc_t          wpc,
    input  logic          enb_n,
    input  logic [CW-1:0] cells_ready,
    input  word_t         head_word,
    output logic          pop,
    output logic          cell_start,
    output beat_t         beat
);

    wpc_t idx;
    logic mid_cell, go;

    assign mid_cell   = (idx != '0);
    assign go         = !enb_n && (mid_cell || (cells_ready != '0));
    assign pop        = go;
    assign cell_start = go && !mid_cell;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            beat <= '0;
        end else begin
            beat.valid <= go;
            if (go) begin
                beat.data <= head_word;
                beat.soc  <= !mid_cell;
                idx       <= (idx == wpc - 7'd1) ? '0 : idx + 7'd1;
            end
        end
    end

    AST_IDX_IN_CELL: assert property (@(posedge clk) disable iff (rst)
        idx < wpc);                                             // R8
    AST_PAUSE_KEEPS_IDX: assert property (@(posedge clk) disable iff (rst)
        enb_n |=> $stable(idx));                                // R5

endmodule

// File: rtl/atm_egress_parity.sv
module atm_egress_parity
    import atm_egress_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t word,
    input  logic  par_en,
    input  logic  par_odd,
    output logic  prty
);

    always_ff @(posedge clk) begin
        if (rst)       prty <= 1'b0;
        else if (load) prty <= word_parity(word, par_en, par_odd);
    end

endmodule

// File: rtl/atm_cell_egress.sv
module atm_cell_egress
    import atm_egress_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = AW + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cfg_cell_bytes,
    input  logic        cfg_par_en,
    input  logic        cfg_par_odd,
    input  logic        wr_en,
    input  logic [15:0] wr_word,
    output logic        wr_full,
    input  logic        rx_enb_n,
    output logic        rx_clav,
    output logic [15:0] rx_data,
    output logic        rx_soc,
    output logic        rx_prty,
    output logic        rx_valid
);

    wpc_t          wpc;
    word_t         head_word;
    logic [CW-1:0] cells_ready;
    logic          pop, cell_start;
    beat_t         beat;

    assign wpc = cell_words(cfg_cell_bytes);

    atm_egress_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .wpc        (wpc),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .full       (wr_full),
        .pop        (pop),
        .cell_start (cell_start),
        .head_word  (head_word),
        .cells_ready(cells_ready)
    );

    atm_egress_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wpc        (wpc),
        .enb_n      (rx_enb_n),
        .cells_ready(cells_ready),
        .head_word  (head_word),
        .pop        (pop),
        .cell_start (cell_start),
        .beat       (beat)
    );

    atm_egress_parity u_par (
        .clk    (clk),
        .rst    (rst),
        .load   (pop),
        .word   (head_word),
        .par_en (cfg_par_en),
        .par_odd(cfg_par_odd),
        .prty   (rx_prty)
    );

    assign rx_clav  = (cells_ready != '0);
    assign rx_data  = beat.data;
    assign rx_soc   = beat.soc;
    assign rx_valid = beat.valid;

    AST_WORD_AFTER_ENABLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(!rx_enb_n));                         // R2
    AST_SOC_NEEDS_CLAV: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_soc) |-> $past(rx_clav));               // R4
    AST_IDLE_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !$past(rst)) |->
            ($stable(rx_data) && $stable(rx_soc) && $stable(rx_prty))); // R10
    AST_PARITY_SENSE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_par_en) |-> ((^{rx_data, rx_prty}) == cfg_par_odd)); // R9
    AST_PARITY_OFF: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_par_en) |-> !rx_prty);                // R9

endmodule

// File: tb/tb_atm_cell_egress.sv
module tb_atm_cell_egress;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_cell_bytes = 8'd16;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        wr_full;
    logic        rx_enb_n = 1'b1;
    logic        rx_clav;
    logic [15:0] rx_data;
    logic        rx_soc;
    logic        rx_prty;
    logic        rx_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    atm_cell_egress #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .cfg_cell_bytes(cfg_cell_bytes),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .wr_en(wr_en), .wr_word(wr_word), .wr_full(wr_full),
        .rx_enb_n(rx_enb_n), .rx_clav(rx_clav), .rx_data(rx_data),
        .rx_soc(rx_soc), .rx_prty(rx_prty), .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    logic [15:0] q[$];
    int          complete, started, idx, acc_words, wpc;
    int          wcell, wword;
    logic [15:0] last_data;
    logic        last_soc, last_prty;

    task automatic run_config(input logic [7:0] bytes, input bit pen, input bit podd,
                              input int enb_mode, input int wr_mode, input int ncyc,
                              input logic [15:0] seed);
        logic [15:0] lfsr = seed;
        rst = 1'b1; wr_en = 1'b0; rx_enb_n = 1'b1;
        cfg_cell_bytes = bytes; cfg_par_en = pen; cfg_par_odd = podd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q.delete(); complete = 0; started = 0; idx = 0; acc_words = 0;
        wcell = 0; wword = 0; last_data = '0; last_soc = 1'b0; last_prty = 1'b0;
        wpc = int'(bytes[7:1]);
        // R1: reset state
        chk(!rx_valid && !rx_clav && !rx_soc && !rx_prty && !wr_full && rx_data == 16'h0,
            "R1 reset outputs", {rx_data, 11'h0, rx_valid, rx_clav, rx_soc, rx_prty, wr_full}, 0);
        for (int c = 0; c < ncyc; c++) begin
            bit enb_low, go, acc, exp_soc, exp_prty, b2b;
            logic [15:0] exp_data;
            int ready;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (enb_mode)
                0: enb_low = 1'b1;
                1: enb_low = lfsr[0] | lfsr[3];
                2: enb_low = (c >= 150);
                default: enb_low = (c % 5) != 4;
            endcase
            wr_en   = (wr_mode == 0) ? 1'b1 : ((c % 3) == 0);
            wr_word = {wcell[7:0], wword[7:0]};
            rx_enb_n = !enb_low;
            // R11: full flag reflects stored words
            chk(wr_full == (q.size() == DEPTH), "R11 wr_full", wr_full, q.size() == DEPTH);
            ready = complete - started;
            acc = wr_en && (q.size() < DEPTH);
            go = enb_low && (idx != 0 || ready > 0);
            b2b = enb_low && idx == 0 && ready > 0 && rx_valid && !(c == 0);
            exp_soc = 1'b0; exp_data = '0;
            if (go) begin
                exp_data = q.pop_front();
                exp_soc  = (idx == 0);
                if (idx == 0) started++;
                idx = (idx + 1 == wpc) ? 0 : idx + 1;
            end
            if (acc) begin
                q.push_back(wr_word);
                acc_words++;
                if (acc_words % wpc == 0) complete++;
                wword++;
                if (wword == wpc) begin wword = 0; wcell++; end
            end
            exp_prty = pen ? ((^exp_data) ^ podd) : 1'b0;
            @(posedge clk);
            @(negedge clk);
            // R2 / R5 / R7: word only when enabled and something to send
            chk(rx_valid == go, "R2 R5 R7 rx_valid", rx_valid, go);
            if (go) begin
                chk(rx_data == exp_data, "R8 R11 rx_data order", rx_data, exp_data);
                chk(rx_soc == exp_soc, "R4 rx_soc", rx_soc, exp_soc);
                chk(rx_prty == exp_prty, "R9 rx_prty", rx_prty, exp_prty);
                if (b2b) chk(rx_soc == 1'b1, "R6 back-to-back soc", rx_soc, 1);
                last_data = exp_data; last_soc = exp_soc; last_prty = exp_prty;
            end else begin
                chk(rx_data == last_data && rx_soc == last_soc && rx_prty == last_prty,
                    "R10 hold when idle", {rx_data, rx_soc, rx_prty}, {last_data, last_soc, last_prty});
            end
            chk(rx_clav == (complete - started > 0), "R3 rx_clav", rx_clav, complete - started > 0);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        run_config(8'd16,  1'b1, 1'b1, 0, 0, 600, 16'hACE1);
        run_config(8'd19,  1'b1, 1'b0, 1, 0, 600, 16'h1D2C);
        run_config(8'd24,  1'b0, 1'b0, 3, 1, 600, 16'h7777);
        run_config(8'd128, 1'b1, 1'b1, 2, 0, 600, 16'hBEEF);
        run_config(8'd16,  1'b1, 1'b1, 2, 0, 600, 16'h0F0F);
        run_config(8'd32,  1'b1, 1'b0, 0, 1, 600, 16'h5A5A);
        run_config(8'd128, 1'b0, 1'b1, 1, 1, 600, 16'h3C3C);
        run_config(8'd16,  1'b0, 1'b1, 1, 1, 600, 16'h9999);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule